// File: doc/BRIEF.md
# PCI Base Address Allocator

This block hands out bus addresses to PCI functions while the system is enumerated. It keeps two running cursors, one for I/O space and one for memory space. A request names a target function together with an I/O window size and a memory window size. Each size is either zero or a power of two. For every nonzero size the block rounds the matching cursor up to a multiple of that size. It then writes a base-address register and its size mask into the configuration image through a single write port, and moves the cursor past the new window.

When all writes for a request have gone out, the block pulses `done`. With that pulse it returns both addresses, each shifted by a fixed translation offset for its own space. Each function owns a fixed number of base-address slots. A request that would overflow them is refused with an error flag and changes nothing.

Top module: `pci_bar_allocator`

## Requirements
- R1: After reset the I/O cursor equals `IO_BASE + 0x10000` and the memory cursor equals `MEM_BASE + 0x10000`.
- R2: For a nonzero size S (a power of two) the window starts at `((cursor - 1) | (S - 1)) + 1`. A cursor that is already a multiple of S is used unchanged.
- R3: An I/O window is written with bit 0 of the register value set to 1. A memory window is written with bit 0 cleared.
- R4: Each write carries a size mask equal to S - 1.
- R5: Within one function, slots are used in order. Slot k is written at byte offset `0x10 + 4*k`. When a request has both sizes nonzero, the I/O write comes first, in the cycle before the memory write.
- R6: A zero size produces no write and leaves that cursor unchanged. It still returns the current cursor of that space.
- R7: The returned I/O address equals the I/O bus address plus `IO_XLAT`. The returned memory address equals the memory bus address plus `MEM_XLAT`.
- R8: After an allocation of size S the cursor equals the window start plus S.
- R9: Each function has `SLOTS` slots (default 6). A request that needs more than remain is refused. It gets `done` with `done_err` = 1, and it produces no write and no change to any cursor or slot count.
- R10: `req_ready` is high only while the block is idle, and a request is taken when `req_valid` and `req_ready` are both high. `done` is a single-cycle pulse in the cycle after the last write, or in the cycle after acceptance when there is no write. `req_ready` returns in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_func | input | FUNC_W | Target function index |
| req_io_size | input | ADDR_W | I/O window size (0 or power of two) |
| req_mem_size | input | ADDR_W | Memory window size (0 or power of two) |
| cfg_wr_en | output | 1 | Configuration write strobe |
| cfg_wr_func | output | FUNC_W | Function being written |
| cfg_wr_ofs | output | 8 | Byte offset of the base-address register |
| cfg_wr_bar | output | ADDR_W | Register value (base, bit 0 = I/O flag) |
| cfg_wr_mask | output | ADDR_W | Size mask for the register |
| done | output | 1 | Request finished (one cycle) |
| done_err | output | 1 | Request refused for lack of slots |
| done_io_addr | output | ADDR_W | Translated I/O address |
| done_mem_addr | output | ADDR_W | Translated memory address |

## Verification
The assertions take for granted that every accepted size is zero or a power of two. They also take for granted that the cursors never wrap around the address width, because the alignment and mask checks only mean something under those conditions. The stimulus uses small power-of-two sizes, from 0x10 up to 0x1000, starting from default bases that leave gigabytes of headroom. A scoreboard cursor model in the bench predicts every window, and slot exhaustion is reached on purpose through a chain of requests to a single function.

// File: rtl/bar_alloc_pkg.sv
package bar_alloc_pkg;
    parameter int ADDR_W = 32;
    typedef logic [ADDR_W-1:0] addr_t;

    // Space left free below each cursor for legacy devices
    localparam addr_t LEGACY_GAP = addr_t'(32'h0001_0000);
    // Byte offset of the first base-address register
    localparam logic [7:0] BAR_FIRST_OFS = 8'h10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_IO,
        ST_WR_MEM,
        ST_DONE
    } alloc_state_e;

    typedef struct packed {
        logic [7:0] ofs;
        addr_t      bar;
        addr_t      mask;
    } bar_write_t;

    function automatic addr_t align_up(addr_t cur, addr_t size);
        return (size == '0) ? cur : (((cur - addr_t'(1)) | (size - addr_t'(1))) + addr_t'(1));
    endfunction

    function automatic logic pow2_or_zero(addr_t v);
        return (v & (v - addr_t'(1))) == '0;
    endfunction

    function automatic logic [7:0] slot_ofs(logic [7:0] slot);
        return BAR_FIRST_OFS + (slot << 2);
    endfunction
endpackage

// File: rtl/bar_space_cursor.sv
module bar_space_cursor
    import bar_alloc_pkg::*;
#(
    parameter addr_t BASE = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t size,
    input  logic  commit,
    output addr_t aligned,
    output addr_t cur
);
    addr_t cur_q;

    assign aligned = align_up(cur_q, size);
    assign cur     = cur_q;

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= BASE + LEGACY_GAP;
        else if (commit && size != '0)
            cur_q <= aligned + size;
    end

    // After a nonzero allocation the cursor sits one whole window above an aligned start
    AST_CURSOR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (commit && size != '0) |=> (((cur_q - $past(size)) & ($past(size) - addr_t'(1))) == '0)); // R2
    AST_CURSOR_PAST_OLD: assert property (@(posedge clk) disable iff (rst)
        (commit && size != '0) |=> (cur_q - $past(size)) >= $past(cur_q)); // R8
    AST_CURSOR_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (commit && size == '0) |=> cur_q == $past(cur_q)); // R6
endmodule

// File: rtl/bar_slot_table.sv
module bar_slot_table
    import bar_alloc_pkg::*;
#(
    parameter int FUNC_W = 2,
    parameter int SLOTS  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FUNC_W-1:0] func,
    input  logic [1:0]        need,
    input  logic              commit,
    output logic [7:0]        used
);
    localparam int NUM_FUNC = 1 << FUNC_W;
    localparam int CNT_W    = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] cnt_q [NUM_FUNC];

    for (genvar g = 0; g < NUM_FUNC; g++) begin : g_func
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[g] <= '0;
            else if (commit && func == FUNC_W'(g))
                cnt_q[g] <= cnt_q[g] + CNT_W'(need);
        end

        AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
            int'(cnt_q[g]) <= SLOTS); // R9
    end

    assign used = 8'(cnt_q[func]);
endmodule

// File: rtl/pci_bar_allocator.sv
module pci_bar_allocator
    import bar_alloc_pkg::*;
#(
    parameter int    FUNC_W   = 2,
    parameter int    SLOTS    = 6,
    parameter addr_t IO_BASE  = addr_t'(32'h0000_0000),
    parameter addr_t MEM_BASE = addr_t'(32'h1000_0000),
    parameter addr_t IO_XLAT  = addr_t'(32'h8000_0000),
    parameter addr_t MEM_XLAT = addr_t'(32'h4000_0000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [FUNC_W-1:0] req_func,
    input  addr_t             req_io_size,
    input  addr_t             req_mem_size,
    output logic              cfg_wr_en,
    output logic [FUNC_W-1:0] cfg_wr_func,
    output logic [7:0]        cfg_wr_ofs,
    output addr_t             cfg_wr_bar,
    output addr_t             cfg_wr_mask,
    output logic              done,
    output logic              done_err,
    output addr_t             done_io_addr,
    output addr_t             done_mem_addr
);
    alloc_state_e      state_q;
    logic [FUNC_W-1:0] func_q;
    addr_t             io_sz_q, mem_sz_q, io_addr_q, mem_addr_q;
    logic [7:0]        slot_q;
    logic              err_q;

    logic       accept, io_need, mem_need, reject, commit;
    logic [1:0] need;
    logic [7:0] used;
    addr_t      io_aligned, mem_aligned, io_cur, mem_cur;
    bar_write_t wr;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign io_need   = (req_io_size != '0);
    assign mem_need  = (req_mem_size != '0);
    assign need      = {1'b0, io_need} + {1'b0, mem_need};
    assign reject    = (int'(used) + int'(need)) > SLOTS;
    assign commit    = accept && !reject;

    bar_space_cursor #(.BASE(IO_BASE)) i_io_cursor (
        .clk(clk), .rst(rst), .size(req_io_size), .commit(commit),
        .aligned(io_aligned), .cur(io_cur)
    );

    bar_space_cursor #(.BASE(MEM_BASE)) i_mem_cursor (
        .clk(clk), .rst(rst), .size(req_mem_size), .commit(commit),
        .aligned(mem_aligned), .cur(mem_cur)
    );

    bar_slot_table #(.FUNC_W(FUNC_W), .SLOTS(SLOTS)) i_slots (
        .clk(clk), .rst(rst), .func(req_func), .need(need),
        .commit(commit), .used(used)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            func_q     <= '0;
            io_sz_q    <= '0;
            mem_sz_q   <= '0;
            io_addr_q  <= '0;
            mem_addr_q <= '0;
            slot_q     <= '0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    func_q     <= req_func;
                    io_sz_q    <= req_io_size;
                    mem_sz_q   <= req_mem_size;
                    io_addr_q  <= reject ? io_cur  : io_aligned;
                    mem_addr_q <= reject ? mem_cur : mem_aligned;
                    slot_q     <= used;
                    err_q      <= reject;
                    if (reject)        state_q <= ST_DONE;
                    else if (io_need)  state_q <= ST_WR_IO;
                    else if (mem_need) state_q <= ST_WR_MEM;
                    else               state_q <= ST_DONE;
                end
                ST_WR_IO:  state_q <= (mem_sz_q != '0) ? ST_WR_MEM : ST_DONE;
                ST_WR_MEM: state_q <= ST_DONE;
                ST_DONE:   state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr = '0;
        if (state_q == ST_WR_IO) begin
            wr.ofs  = slot_ofs(slot_q);
            wr.bar  = io_addr_q | addr_t'(1);
            wr.mask = io_sz_q - addr_t'(1);
        end else if (state_q == ST_WR_MEM) begin
            wr.ofs  = slot_ofs(slot_q + ((io_sz_q != '0) ? 8'd1 : 8'd0));
            wr.bar  = mem_addr_q & ~addr_t'(1);
            wr.mask = mem_sz_q - addr_t'(1);
        end
    end

    assign cfg_wr_en     = (state_q == ST_WR_IO) || (state_q == ST_WR_MEM);
    assign cfg_wr_func   = func_q;
    assign cfg_wr_ofs    = wr.ofs;
    assign cfg_wr_bar    = wr.bar;
    assign cfg_wr_mask   = wr.mask;
    assign done          = (state_q == ST_DONE);
    assign done_err      = done && err_q;
    assign done_io_addr  = io_addr_q + IO_XLAT;
    assign done_mem_addr = mem_addr_q + MEM_XLAT;

    AST_SIZE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        accept |-> (pow2_or_zero(req_io_size) && pow2_or_zero(req_mem_size))); // R2
    AST_IO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_IO) |-> (cfg_wr_en && cfg_wr_bar[0])); // R3
    AST_MEM_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_MEM) |-> (cfg_wr_en && !cfg_wr_bar[0])); // R3
    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> (((cfg_wr_mask + addr_t'(1)) & cfg_wr_mask) == '0)); // R4
    AST_BAR_ON_MASK: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> ((cfg_wr_bar & cfg_wr_mask & ~addr_t'(1)) == '0)); // R2
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_err |-> $past(!cfg_wr_en)); // R9
    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready)); // R10
endmodule

// File: tb/test_pci_bar_allocator.sv
module test_pci_bar_allocator;
    import bar_alloc_pkg::*;

    localparam addr_t IO_BASE  = addr_t'(32'h0000_0000);
    localparam addr_t MEM_BASE = addr_t'(32'h1000_0000);
    localparam addr_t IO_XLAT  = addr_t'(32'h8000_0000);
    localparam addr_t MEM_XLAT = addr_t'(32'h4000_0000);
    localparam int    SLOTS    = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_func = '0;
    addr_t      req_io_size = '0, req_mem_size = '0;
    logic       cfg_wr_en;
    logic [1:0] cfg_wr_func;
    logic [7:0] cfg_wr_ofs;
    addr_t      cfg_wr_bar, cfg_wr_mask;
    logic       done, done_err;
    addr_t      done_io_addr, done_mem_addr;

    always #2ns clk = ~clk;

    pci_bar_allocator #(
        .FUNC_W(2), .SLOTS(SLOTS), .IO_BASE(IO_BASE), .MEM_BASE(MEM_BASE),
        .IO_XLAT(IO_XLAT), .MEM_XLAT(MEM_XLAT)
    ) i_pci_bar_allocator (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_func(req_func), .req_io_size(req_io_size), .req_mem_size(req_mem_size),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_func(cfg_wr_func), .cfg_wr_ofs(cfg_wr_ofs),
        .cfg_wr_bar(cfg_wr_bar), .cfg_wr_mask(cfg_wr_mask), .done(done),
        .done_err(done_err), .done_io_addr(done_io_addr), .done_mem_addr(done_mem_addr)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Write log, captured away from the active edge
    int         nwr = 0;
    logic [1:0] log_func [4];
    logic [7:0] log_ofs  [4];
    addr_t      log_bar  [4];
    addr_t      log_mask [4];
    int         log_cyc  [4];
    int         cyc = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cfg_wr_en && nwr < 4) begin
            log_func[nwr] = cfg_wr_func;
            log_ofs[nwr]  = cfg_wr_ofs;
            log_bar[nwr]  = cfg_wr_bar;
            log_mask[nwr] = cfg_wr_mask;
            log_cyc[nwr]  = cyc;
            nwr = nwr + 1;
        end
    end

    // Independent model
    addr_t m_io, m_mem;
    int    m_used [4];

    function automatic addr_t model_align(addr_t c, addr_t s);
        return (s == '0) ? c : (((c - 1) | (s - 1)) + 1);
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Issue one request and compare everything against the model
    task automatic run_req(string tag, logic [1:0] f, addr_t io, addr_t mem);
        addr_t a_io, a_mem;
        int    need, slot, k, dcyc, waitn;
        bit    rej;
        need  = (io != 0 ? 1 : 0) + (mem != 0 ? 1 : 0);
        rej   = (m_used[f] + need) > SLOTS;
        a_io  = model_align(m_io, io);
        a_mem = model_align(m_mem, mem);
        slot  = m_used[f];
        @(negedge clk);
        nwr = 0;
        req_func = f; req_io_size = io; req_mem_size = mem; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "ready low after accept (R10)", req_ready, 0);
        waitn = 0;
        while (!done && waitn < 10) begin @(negedge clk); waitn++; end
        dcyc = cyc;
        check(tag, "done seen (R10)", done, 1);
        check(tag, "error flag (R9)", done_err, rej);
        if (rej) begin
            check(tag, "no write on reject (R9)", nwr, 0);
        end else begin
            check(tag, "write count (R5/R6)", nwr, need);
            k = 0;
            if (io != 0) begin
                check(tag, "io func (R5)", log_func[k], f);
                check(tag, "io offset (R5)", log_ofs[k], 8'h10 + 4 * slot);
                check(tag, "io bar value (R2/R3)", log_bar[k], a_io | 1);
                check(tag, "io mask (R4)", log_mask[k], io - 1);
                k++;
            end
            if (mem != 0) begin
                check(tag, "mem func (R5)", log_func[k], f);
                check(tag, "mem offset (R5)", log_ofs[k], 8'h10 + 4 * (slot + k));
                check(tag, "mem bar value (R2/R3)", log_bar[k], a_mem);
                check(tag, "mem mask (R4)", log_mask[k], mem - 1);
                k++;
            end
            if (need == 2)
                check(tag, "io write one cycle before mem (R5)", log_cyc[1] - log_cyc[0], 1);
            if (need > 0)
                check(tag, "done right after last write (R10)", dcyc - log_cyc[need-1], 1);
            check(tag, "io address (R7)", done_io_addr, a_io + IO_XLAT);
            check(tag, "mem address (R7)", done_mem_addr, a_mem + MEM_XLAT);
            if (io != 0)  m_io  = a_io + io;
            if (mem != 0) m_mem = a_mem + mem;
            m_used[f] += need;
        end
        @(negedge clk);
        check(tag, "done one cycle (R10)", done, 0);
        check(tag, "ready back (R10)", req_ready, 1);
    endtask

    task automatic t_reset();
        check("R1", "ready after reset", req_ready, 1);
        check("R1", "done after reset", done, 0);
        check("R1", "no write after reset", cfg_wr_en, 0);
        // Zero-size request reveals both reset cursors
        run_req("R1", 2'd3, 0, 0);
        check("R1", "io cursor start", done_io_addr, IO_BASE + 32'h10000 + IO_XLAT);
        check("R1", "mem cursor start", done_mem_addr, MEM_BASE + 32'h10000 + MEM_XLAT);
    endtask

    task automatic t_both();   run_req("R5", 2'd0, 32'h100, 32'h100); endtask
    task automatic t_align();  run_req("R2", 2'd1, 32'h400, 0);       endtask
    task automatic t_memonly();run_req("R6", 2'd1, 0, 32'h1000);      endtask
    task automatic t_aligned_already();
        // io cursor is 0x10800 here, already a multiple of 0x800
        run_req("R8", 2'd2, 32'h800, 32'h10);
        check("R8", "io window start", done_io_addr, 32'h10800 + IO_XLAT);
    endtask
    task automatic t_exhaust();
        run_req("R9", 2'd0, 32'h10, 32'h10);
        run_req("R9", 2'd0, 32'h10, 32'h10);
        run_req("R9", 2'd0, 32'h20, 0);           // refused: 6 slots used
        run_req("R9", 2'd2, 32'h10, 32'h20);      // cursors unchanged by refusal
        run_req("R9", 2'd0, 0, 0);                // zero need still fits
    endtask

    initial begin
        m_io  = IO_BASE + 32'h10000;
        m_mem = MEM_BASE + 32'h10000;
        for (int i = 0; i < 4; i++) m_used[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_both();
        t_align();
        t_memonly();
        t_aligned_already();
        t_exhaust();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule